// File: doc/BRIEF.md
# Dual Bridge Protection Controller

This block sits between a set of already-digitised protection comparators and the enables of four half-bridge power channels, A, B, C and D. A and B form one pair and C and D the other. It decides, every clock cycle, which channels must be parked in high impedance and which of them should have their weak pulldowns switched on. It also drives two active-low status pins: one warns of an elevated temperature, the other reports a fault.

Each class of fault leaves in its own way. A thermal shutdown is held until both pair resets are low together. An undervoltage condition lets go as soon as every supply flag is clean again. An overcurrent trip in latching mode stays until its own pair reset goes high again. In current-limit mode an overcurrent only parks the offending channel while its flag is present. Every input is asynchronous to the clock and passes through a two-flop synchroniser before any decision is made.

Top module: `bridge_guard`

## Requirements
- R1: `warn_n_o` is low exactly while the synchronised temperature-warning flag is high, and the warning alone changes no other output.
- R2: A high thermal-shutdown flag drives all four `hiz_o` bits high and `fault_n_o` low, and this state is kept after the flag falls.
- R3: A held thermal shutdown clears only in a cycle where both synchronised pair resets are low and the shutdown flag is low; one pair reset pulsed alone leaves it in place.
- R4: Any bit of `uv_i` high (1 = undervoltage on that supply) drives all four `hiz_o` bits high and `fault_n_o` low.
- R5: Once every `uv_i` bit is low again, the channels return to normal operation with no reset.
- R6: `rst_ab_n_i` low sets `hiz_o[1:0]` (channels A, B) and `rst_cd_n_i` low sets `hiz_o[3:2]` (channels C, D), with each pair independent of the other.
- R7: While either pair reset is low, `fault_n_o` is high whatever faults are present.
- R8: `pulldown_o` bits of a pair are high while that pair's reset is low and `bridge_cfg_i` is 2'b00 (full bridge) or 2'b01 (parallel full bridge); for 2'b10 (half bridge) and 2'b11 they stay low. A pulldown is only ever on for a channel that is in Hi-Z.
- R9: With `cur_limit_i` = 0, an overcurrent flag on either channel of a pair sets both of that pair's `hiz_o` bits and pulls `fault_n_o` low. This holds after the flag falls, until a rising edge of that pair's own reset.
- R10: With `cur_limit_i` = 1, an overcurrent flag sets only its own channel's `hiz_o` bit, and only while the flag is high; `fault_n_o` is not affected and nothing is held.
- R11: A change on an input reaches the outputs on the second rising clock edge after it is applied, not the first.
- R12: `rst` clears the thermal and overcurrent holds. After reset, all channels stay in Hi-Z until the synchronised supply flags show no undervoltage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| temp_warn_i | input | 1 | Over-temperature warning comparator flag |
| temp_shut_i | input | 1 | Thermal-shutdown comparator flag |
| uv_i | input | NUM_SUPPLY | Per-supply undervoltage flags, 1 = low supply |
| oc_i | input | 4 | Per-channel overcurrent flags, bit 0 = A ... bit 3 = D |
| cur_limit_i | input | 1 | 1 = current-limit mode, 0 = latching overcurrent |
| bridge_cfg_i | input | 2 | 00 full, 01 parallel full, 10 half bridge, 11 treated like half |
| rst_ab_n_i | input | 1 | Active-low reset of channels A and B |
| rst_cd_n_i | input | 1 | Active-low reset of channels C and D |
| hiz_o | output | 4 | Per-channel high-impedance enable |
| pulldown_o | output | 4 | Per-channel weak-pulldown enable |
| warn_n_o | output | 1 | Active-low temperature warning |
| fault_n_o | output | 1 | Active-low fault |

## Verification
The assertions assume that every input has already crossed the two-flop synchroniser, so they reason only about the synchronised copies and treat a flag as lasting at least one clock. They also assume the configuration and mode inputs change only together with, or while, the overcurrent flags are quiet, so that no trip is caught half-way through a mode switch. The stimulus applies each new input set on a falling edge, holds it for four cycles so the synchroniser and the holding flops have settled, and switches mode only in the same step that clears the overcurrent flags.

// File: rtl/bridge_guard_pkg.sv
package bridge_guard_pkg;

    localparam int NUM_PAIRS   = 2;
    localparam int CH_PER_PAIR = 2;
    localparam int NUM_CH      = NUM_PAIRS * CH_PER_PAIR;

    typedef enum logic [1:0] {
        CFG_FULL     = 2'b00,
        CFG_PARALLEL = 2'b01,
        CFG_HALF     = 2'b10,
        CFG_HALF_ALT = 2'b11
    } bridge_cfg_e;

    // Synchronised view of the non-supply inputs.
    typedef struct packed {
        logic                 warn;
        logic                 shut;
        logic [NUM_CH-1:0]    oc;
        logic                 limit;
        bridge_cfg_e          cfg;
        logic [NUM_PAIRS-1:0] rst_n;   // bit 0 = pair A/B, bit 1 = pair C/D
    } sync_in_t;

    function automatic logic cfg_allows_pulldown(input bridge_cfg_e cfg);
        return (cfg == CFG_FULL) || (cfg == CFG_PARALLEL);
    endfunction

endpackage

// File: rtl/bg_sync.sv
module bg_sync #(
    parameter int               WIDTH     = 1,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) begin
                stage_q[k] <= RESET_VAL;
            end
        end else begin
            stage_q[0] <= d_i;
            for (int k = 1; k < STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/bg_thermal.sv
module bg_thermal (
    input  logic clk,
    input  logic rst,
    input  logic shut_i,    // synchronised shutdown flag
    input  logic clear_i,   // both pair resets low
    output logic off_o
);

    logic hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
        end else begin
            hold_q <= shut_i | (hold_q & ~clear_i);
        end
    end

    assign off_o = shut_i | hold_q;

    // R2: a shutdown flag is always captured
    assert_therm_capture_R2: assert property (@(posedge clk) disable iff (rst)
        shut_i |=> hold_q);

    // R3: without both resets low the hold never drops
    assert_therm_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (hold_q && !clear_i) |=> hold_q);

endmodule

// File: rtl/bg_pair_ctrl.sv
module bg_pair_ctrl #(
    parameter int CH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          global_off_i,   // undervoltage or thermal
    input  logic          limit_i,        // current-limit mode
    input  logic          pd_allow_i,     // configuration permits pulldown
    input  logic          rst_n_i,        // synchronised pair reset
    input  logic [CH-1:0] oc_i,           // synchronised overcurrent flags
    output logic [CH-1:0] hiz_o,
    output logic [CH-1:0] pd_o,
    output logic          trip_o
);

    logic rst_n_d;
    logic rise;
    logic trip_q;
    logic oc_any;

    assign oc_any = |oc_i;
    assign rise   = rst_n_i & ~rst_n_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_n_d <= 1'b0;
            trip_q  <= 1'b0;
        end else begin
            rst_n_d <= rst_n_i;
            trip_q  <= ~limit_i & (oc_any | (trip_q & ~rise));
        end
    end

    assign trip_o = ~limit_i & (trip_q | oc_any);

    always_comb begin
        for (int i = 0; i < CH; i++) begin
            hiz_o[i] = global_off_i | ~rst_n_i | trip_o | (limit_i & oc_i[i]);
            pd_o[i]  = ~rst_n_i & pd_allow_i;
        end
    end

    // R6: a low pair reset parks every channel of the pair
    assert_rst_hiz_R6: assert property (@(posedge clk) disable iff (rst)
        !rst_n_i |-> (&hiz_o));

    // R8: pulldown only on channels already in Hi-Z
    assert_pd_hiz_R8: assert property (@(posedge clk) disable iff (rst)
        (|pd_o) |-> ((pd_o & hiz_o) == pd_o));

    // R9: a latched trip survives until a reset rising edge
    assert_oc_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (trip_q && !rise && !limit_i) |=> trip_q);

    // R10: limit mode never leaves a held trip
    assert_limit_nohold_R10: assert property (@(posedge clk) disable iff (rst)
        limit_i |=> !trip_q);

endmodule

// File: rtl/bridge_guard.sv
module bridge_guard
    import bridge_guard_pkg::*;
#(
    parameter int NUM_SUPPLY  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  temp_warn_i,
    input  logic                  temp_shut_i,
    input  logic [NUM_SUPPLY-1:0] uv_i,
    input  logic [NUM_CH-1:0]     oc_i,
    input  logic                  cur_limit_i,
    input  logic [1:0]            bridge_cfg_i,
    input  logic                  rst_ab_n_i,
    input  logic                  rst_cd_n_i,
    output logic [NUM_CH-1:0]     hiz_o,
    output logic [NUM_CH-1:0]     pulldown_o,
    output logic                  warn_n_o,
    output logic                  fault_n_o
);

    localparam int SYNC_W = $bits(sync_in_t);

    sync_in_t              raw_in;
    sync_in_t              syn;
    logic [NUM_SUPPLY-1:0] uv_s;
    logic                  uv_any;
    logic                  therm_off;
    logic                  global_off;
    logic                  pd_allow;
    logic [NUM_PAIRS-1:0]  trip;

    always_comb begin
        raw_in.warn  = temp_warn_i;
        raw_in.shut  = temp_shut_i;
        raw_in.oc    = oc_i;
        raw_in.limit = cur_limit_i;
        raw_in.cfg   = bridge_cfg_e'(bridge_cfg_i);
        raw_in.rst_n = {rst_cd_n_i, rst_ab_n_i};
    end

    bg_sync #(
        .WIDTH     (SYNC_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ('0)
    ) u_sync_ctl (
        .clk (clk),
        .rst (rst),
        .d_i (raw_in),
        .q_o (syn)
    );

    // Supplies reset to "undervoltage" so the channels stay parked until good.
    bg_sync #(
        .WIDTH     (NUM_SUPPLY),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ({NUM_SUPPLY{1'b1}})
    ) u_sync_uv (
        .clk (clk),
        .rst (rst),
        .d_i (uv_i),
        .q_o (uv_s)
    );

    assign uv_any = |uv_s;

    bg_thermal u_therm (
        .clk     (clk),
        .rst     (rst),
        .shut_i  (syn.shut),
        .clear_i (~|syn.rst_n),
        .off_o   (therm_off)
    );

    assign global_off = uv_any | therm_off;
    assign pd_allow   = cfg_allows_pulldown(syn.cfg);

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        bg_pair_ctrl #(
            .CH (CH_PER_PAIR)
        ) u_pair (
            .clk          (clk),
            .rst          (rst),
            .global_off_i (global_off),
            .limit_i      (syn.limit),
            .pd_allow_i   (pd_allow),
            .rst_n_i      (syn.rst_n[p]),
            .oc_i         (syn.oc[p*CH_PER_PAIR +: CH_PER_PAIR]),
            .hiz_o        (hiz_o[p*CH_PER_PAIR +: CH_PER_PAIR]),
            .pd_o         (pulldown_o[p*CH_PER_PAIR +: CH_PER_PAIR]),
            .trip_o       (trip[p])
        );
    end

    assign warn_n_o  = ~syn.warn;
    assign fault_n_o = (&syn.rst_n) ? ~(global_off | (|trip)) : 1'b1;

    // R4: any undervoltage parks every channel
    assert_uv_hiz_R4: assert property (@(posedge clk) disable iff (rst)
        uv_any |-> (&hiz_o));

    // R7: a low pair reset masks the fault pin
    assert_fault_mask_R7: assert property (@(posedge clk) disable iff (rst)
        !(&syn.rst_n) |-> fault_n_o);

    // R2, R4, R9: a fault report always has a live cause and parks a channel
    assert_fault_cause_R9: assert property (@(posedge clk) disable iff (rst)
        !fault_n_o |-> (|hiz_o));

    // R1: the warning never parks a channel on its own
    assert_warn_passive_R1: assert property (@(posedge clk) disable iff (rst)
        (!warn_n_o && !global_off && (&syn.rst_n) && !(|trip) && !(|syn.oc)) |-> (hiz_o == '0));

endmodule

// File: tb/test_bridge_guard.sv
module test_bridge_guard;

    logic       clk = 1'b0;
    logic       rst;
    logic       temp_warn_i;
    logic       temp_shut_i;
    logic [1:0] uv_i;
    logic [3:0] oc_i;
    logic       cur_limit_i;
    logic [1:0] bridge_cfg_i;
    logic       rst_ab_n_i;
    logic       rst_cd_n_i;
    logic [3:0] hiz_o;
    logic [3:0] pulldown_o;
    logic       warn_n_o;
    logic       fault_n_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bridge_guard i_bridge_guard (
        .clk          (clk),
        .rst          (rst),
        .temp_warn_i  (temp_warn_i),
        .temp_shut_i  (temp_shut_i),
        .uv_i         (uv_i),
        .oc_i         (oc_i),
        .cur_limit_i  (cur_limit_i),
        .bridge_cfg_i (bridge_cfg_i),
        .rst_ab_n_i   (rst_ab_n_i),
        .rst_cd_n_i   (rst_cd_n_i),
        .hiz_o        (hiz_o),
        .pulldown_o   (pulldown_o),
        .warn_n_o     (warn_n_o),
        .fault_n_o    (fault_n_o)
    );

    // Fields: warn, uv[1:0], oc[3:0], limit, cfg[1:0], rst_ab_n, rst_cd_n,
    //         exp hiz[3:0], exp pulldown[3:0], exp warn_n, exp fault_n
    localparam logic [21:0] VEC [12] = '{
        22'b0_00_0000_0_00_1_1_0000_0000_1_1,   // normal
        22'b1_00_0000_0_00_1_1_0000_0000_0_1,   // R1 warning only
        22'b0_01_0000_0_00_1_1_1111_0000_1_0,   // R4 supply 0 low
        22'b0_10_0000_0_00_1_1_1111_0000_1_0,   // R4 supply 1 low
        22'b0_00_0000_0_00_1_1_0000_0000_1_1,   // R5 automatic recovery
        22'b0_00_0000_0_00_0_1_0011_0011_1_1,   // R6 R8 A/B reset, full
        22'b0_00_0000_0_01_1_0_1100_1100_1_1,   // R6 R8 C/D reset, parallel
        22'b0_00_0000_0_10_0_0_1111_0000_1_1,   // R8 both reset, half
        22'b0_01_0000_0_00_0_1_1111_0011_1_1,   // R7 fault masked
        22'b0_00_0100_1_00_1_1_0100_0000_1_1,   // R10 limit, channel C
        22'b1_00_0001_1_00_1_1_0001_0000_0_1,   // R10 R1 limit, channel A
        22'b0_00_0000_0_00_1_1_0000_0000_1_1    // R10 nothing held
    };

    task automatic check(input string req, input logic [9:0] exp);
        logic [9:0] act;
        act = {hiz_o, pulldown_o, warn_n_o, fault_n_o};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst          = 1'b1;
        temp_warn_i  = 1'b0;
        temp_shut_i  = 1'b0;
        uv_i         = 2'b11;
        oc_i         = 4'b0000;
        cur_limit_i  = 1'b0;
        bridge_cfg_i = 2'b00;
        rst_ab_n_i   = 1'b1;
        rst_cd_n_i   = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12 reset state", 10'b1111_1111_1_1);
        rst = 1'b0;
        settle();
        check("R12 held until supplies good", 10'b1111_0000_1_0);
        uv_i = 2'b00;
        settle();
        check("R12 released when supplies good", 10'b0000_0000_1_1);

        // Table walk: R1 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < 12; i++) begin
            {temp_warn_i, uv_i, oc_i, cur_limit_i, bridge_cfg_i,
             rst_ab_n_i, rst_cd_n_i} = VEC[i][21:10];
            settle();
            check($sformatf("table row %0d (R1 R4 R5 R6 R7 R8 R10)", i), VEC[i][9:0]);
        end

        // R11: two-edge latency
        temp_warn_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R11 no change after one edge", 10'b0000_0000_1_1);
        @(posedge clk);
        @(negedge clk);
        check("R11 change after two edges", 10'b0000_0000_0_1);
        temp_warn_i = 1'b0;
        settle();

        // R2 / R3: thermal shutdown hold and clear
        temp_shut_i = 1'b1;
        settle();
        check("R2 shutdown", 10'b1111_0000_1_0);
        temp_shut_i = 1'b0;
        settle();
        check("R2 shutdown held", 10'b1111_0000_1_0);
        rst_ab_n_i = 1'b0;
        settle();
        rst_ab_n_i = 1'b1;
        settle();
        check("R3 one reset does not clear", 10'b1111_0000_1_0);
        rst_ab_n_i = 1'b0;
        rst_cd_n_i = 1'b0;
        settle();
        check("R7 both resets low mask fault", 10'b1111_1111_1_1);
        rst_ab_n_i = 1'b1;
        rst_cd_n_i = 1'b1;
        settle();
        check("R3 cleared by both resets", 10'b0000_0000_1_1);

        // R9: latching overcurrent on pair A/B
        oc_i = 4'b0010;
        settle();
        check("R9 trip pair A/B", 10'b0011_0000_1_0);
        oc_i = 4'b0000;
        settle();
        check("R9 trip held", 10'b0011_0000_1_0);
        rst_cd_n_i = 1'b0;
        settle();
        rst_cd_n_i = 1'b1;
        settle();
        check("R9 other pair reset does not clear", 10'b0011_0000_1_0);
        rst_ab_n_i = 1'b0;
        settle();
        check("R9 reset low parks with pulldown", 10'b0011_0011_1_1);
        rst_ab_n_i = 1'b1;
        settle();
        check("R9 cleared on rising edge", 10'b0000_0000_1_1);

        // R12: power-on reset clears an overcurrent hold
        oc_i = 4'b0100;
        settle();
        check("R9 trip pair C/D", 10'b1100_0000_1_0);
        oc_i = 4'b0000;
        settle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        settle();
        check("R12 reset clears hold", 10'b0000_0000_1_1);

        finish_run();
    end

endmodule